// File: doc/BRIEF.md
# Immediate-Controlled Four-Way Element Shuffle

This block rearranges the elements of a 128-bit vector under the control of an 8-bit immediate. For 8, 16 and 32-bit elements the vector is treated as consecutive groups of four elements. Each output element takes one element from its own group, and a 2-bit field of the immediate chooses which one. The same four fields apply to every group. For 64-bit elements the block works across two registers. Each of the two output doublewords takes one of four doublewords, drawn from the source vector and from the prior value of the destination.

An execution pipeline presents both operands, the immediate and a size select, together with a valid strobe. The result is captured in a register and appears one cycle later with its own valid flag. The whole result is computed from the operands as they stand in the issuing cycle. The destination may therefore also be one of the operands.

Top module: `quad_shuffle`

## Requirements
- R1: With size_sel = 2'b00 (8-bit elements, element 0 in bits [7:0]), output byte i equals source byte 4*(i/4) + sel, where sel = imm[2*(i mod 4)+1 : 2*(i mod 4)].
- R2: With size_sel = 2'b01 (16-bit elements), output halfword i equals source halfword 4*(i/4) + sel, with sel taken from imm as in R1.
- R3: With size_sel = 2'b10 (32-bit elements), output word i equals source word sel, with sel = imm[2i+1:2i].
- R4: For 8-bit and 16-bit elements the four 2-bit selectors are applied identically in every group of four elements. No group borrows an element from another group.
- R5: With size_sel = 2'b11 (64-bit elements), output doubleword 0 (bits [63:0]) is chosen by imm[1:0]: 0 gives prior-destination dword 0, 1 gives prior-destination dword 1, 2 gives source dword 0, 3 gives source dword 1.
- R6: With size_sel = 2'b11, output doubleword 1 (bits [127:64]) is chosen by imm[3:2] with the same mapping as R5.
- R7: With size_sel = 2'b11, imm[7:4] has no effect on the result.
- R8: When in_valid is high at a rising clock edge, out_valid is high after that edge and result holds the shuffle of that cycle's inputs. When in_valid is low, out_valid goes low after the edge and result keeps its value.
- R9: A synchronous reset (rst high at a clock edge) clears out_valid and result to zero.
- R10: The result depends only on the operands sampled in the issuing cycle. Feeding the previous result back as prior destination produces the shuffle of that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are presented this cycle |
| size_sel | input | 2 | Element size: 00=8, 01=16, 10=32, 11=64 bits |
| imm | input | 8 | Packed 2-bit selectors |
| src | input | 128 | Source vector |
| dst_prior | input | 128 | Prior destination value (used for 64-bit elements only) |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 128 | Registered shuffle result |

## Verification
The properties assume that the inputs are stable around the sampling edge. They also assume that size_sel carries one of the four defined encodings whenever in_valid is high. Since all four two-bit codes are defined, the stimulus is free to use every one of them. The bench changes its inputs only on the falling clock edge. It drives directed and pseudo-random operands, with in_valid both asserted and idle.

// File: rtl/quad_shuffle_pkg.sv
package quad_shuffle_pkg;
    localparam int VEC_W  = 128;
    localparam int IMM_W  = 8;
    localparam int DW_W   = 64;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } elem_size_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] res;
    } shuf_state_t;
endpackage

// File: rtl/group_lane_shuffle.sv
module group_lane_shuffle
    import quad_shuffle_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [IMM_W-1:0] imm,
    input  logic [VEC_W-1:0] src,
    output logic [VEC_W-1:0] shuffled
);
    localparam int N_EL = VEC_W / EW;

    logic [EW-1:0] elem [N_EL];

    genvar e;
    generate
        for (e = 0; e < N_EL; e++) begin : g_split
            assign elem[e] = src[e*EW +: EW];
        end

        for (e = 0; e < N_EL; e++) begin : g_pick
            localparam int BASE = (e / 4) * 4;
            localparam int POS  = e % 4;
            logic [1:0] pick_sel;
            assign pick_sel = imm[2*POS +: 2];
            always_comb begin
                case (pick_sel)
                    2'd0:    shuffled[e*EW +: EW] = elem[BASE];
                    2'd1:    shuffled[e*EW +: EW] = elem[BASE+1];
                    2'd2:    shuffled[e*EW +: EW] = elem[BASE+2];
                    default: shuffled[e*EW +: EW] = elem[BASE+3];
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/dword_cross_select.sv
module dword_cross_select
    import quad_shuffle_pkg::*;
(
    input  logic [3:0]       ctl,
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst_prior,
    output logic [VEC_W-1:0] picked
);
    localparam int N_DW = VEC_W / DW_W;

    genvar d;
    generate
        for (d = 0; d < N_DW; d++) begin : g_dw
            logic [1:0]       fld;
            logic [VEC_W-1:0] reg_pick;
            assign fld      = ctl[2*d +: 2];
            assign reg_pick = fld[1] ? src : dst_prior;
            assign picked[d*DW_W +: DW_W] =
                fld[0] ? reg_pick[DW_W +: DW_W] : reg_pick[0 +: DW_W];
        end
    endgenerate
endmodule

// File: rtl/quad_shuffle.sv
module quad_shuffle
    import quad_shuffle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       size_sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst_prior,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    localparam int N_LANE_SZ = 3;

    logic [VEC_W-1:0] lane_res [N_LANE_SZ];
    logic [VEC_W-1:0] dw_res;

    genvar s;
    generate
        for (s = 0; s < N_LANE_SZ; s++) begin : g_lane
            group_lane_shuffle #(.EW(8 << s)) u_lane (
                .imm      (imm),
                .src      (src),
                .shuffled (lane_res[s])
            );
        end
    endgenerate

    dword_cross_select u_dw (
        .ctl       (imm[3:0]),
        .src       (src),
        .dst_prior (dst_prior),
        .picked    (dw_res)
    );

    shuf_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            case (elem_size_e'(size_sel))
                SZ_BYTE:  st_d.res = lane_res[0];
                SZ_HALF:  st_d.res = lane_res[1];
                SZ_WORD:  st_d.res = lane_res[2];
                default:  st_d.res = dw_res;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
endmodule

// File: rtl/quad_shuffle_chk.sv
module quad_shuffle_chk
    import quad_shuffle_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       size_sel,
    input logic [IMM_W-1:0] imm,
    input logic [VEC_W-1:0] src,
    input logic [VEC_W-1:0] dst_prior,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_clears_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_idle_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    p_dw0_dst_lo_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b11 && imm[1:0] == 2'd0)
        |=> result[63:0] == $past(dst_prior[63:0]));

    p_dw0_src_hi_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b11 && imm[1:0] == 2'd3)
        |=> result[63:0] == $past(src[127:64]));

    p_dw1_src_lo_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b11 && imm[3:2] == 2'd2)
        |=> result[127:64] == $past(src[63:0]));

    p_byte_identity_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b00 && imm == 8'hE4)
        |=> result == $past(src));

    p_word_broadcast_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_sel == 2'b10 && imm == 8'h00)
        |=> result == {4{$past(src[31:0])}});
endmodule

bind quad_shuffle quad_shuffle_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .size_sel  (size_sel),
    .imm       (imm),
    .src       (src),
    .dst_prior (dst_prior),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/quad_shuffle_test.sv
module quad_shuffle_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   size_sel;
    logic [7:0]   imm;
    logic [127:0] src;
    logic [127:0] dst_prior;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic         exp_vld;
    logic [127:0] exp_res;
    string        cur_tag = "R9";
    string        exp_tag = "R9";

    always #5 clk = ~clk;

    quad_shuffle uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
        .imm(imm), .src(src), .dst_prior(dst_prior),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [127:0] ref_shuffle(input logic [1:0] sz, input logic [7:0] im,
                                                 input logic [127:0] s, input logic [127:0] dp);
        logic [127:0] r;
        r = '0;
        if (sz != 2'b11) begin
            int ew = 8 << sz;
            int n  = 128 / ew;
            for (int i = 0; i < n; i++) begin
                int sel = (im >> (2 * (i % 4))) & 3;
                int j   = (i / 4) * 4 + sel;
                for (int b = 0; b < ew; b++) r[i*ew + b] = s[j*ew + b];
            end
        end else begin
            for (int d = 0; d < 2; d++) begin
                int f = (im >> (2 * d)) & 3;
                logic [127:0] which;
                which = (f >= 2) ? s : dp;
                for (int b = 0; b < 64; b++) r[d*64 + b] = which[(f % 2)*64 + b];
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_vld = 1'b0;
            exp_res = '0;
            exp_tag = "R9";
        end else begin
            exp_vld = in_valid;
            if (in_valid) exp_res = ref_shuffle(size_sel, imm, src, dst_prior);
            exp_tag = in_valid ? cur_tag : "R8";
        end
    end

    task automatic compare();
        checks++;
        if (out_valid !== exp_vld || result !== exp_res) begin
            errors++;
            $display("FAIL %s: out_valid=%b result=%h expected out_valid=%b result=%h",
                     exp_tag, out_valid, result, exp_vld, exp_res);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] sz, input logic [7:0] im,
                        input logic [127:0] s, input logic [127:0] dp, input string tag);
        @(negedge clk);
        compare();
        in_valid  = v;
        size_sel  = sz;
        imm       = im;
        src       = s;
        dst_prior = dp;
        cur_tag   = tag;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    localparam logic [127:0] RAMP = 128'h0F0E0D0C0B0A09080706050403020100;
    localparam logic [127:0] HI   = 128'hAAAAAAAAAAAAAAAABBBBBBBBBBBBBBBB;
    localparam logic [127:0] LO   = 128'hCCCCCCCCCCCCCCCCDDDDDDDDDDDDDDDD;

    initial begin
        rst = 1'b1; in_valid = 1'b0; size_sel = 2'b00; imm = 8'h00;
        src = '0; dst_prior = '0;
        exp_vld = 1'b0; exp_res = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare();
        rst = 1'b0;

        step(1, 2'b00, 8'h1B, RAMP, '0, "R1");
        step(1, 2'b00, 8'hE4, RAMP, '0, "R1");
        step(1, 2'b00, 8'h55, RAMP, '0, "R4");
        step(1, 2'b01, 8'h1B, RAMP, '0, "R2");
        step(1, 2'b01, 8'hAA, RAMP, '0, "R4");
        step(1, 2'b10, 8'h00, RAMP, '0, "R3");
        step(1, 2'b10, 8'h39, RAMP, '0, "R3");
        for (int f = 0; f < 4; f++)
            step(1, 2'b11, 8'(f), HI, LO, "R5");
        for (int f = 0; f < 4; f++)
            step(1, 2'b11, 8'(f << 2), HI, LO, "R6");
        step(1, 2'b11, 8'hF6, HI, LO, "R7");
        step(1, 2'b11, 8'h96, HI, LO, "R7");
        step(0, 2'b00, 8'hFF, rnd128(), rnd128(), "R8");
        step(0, 2'b11, 8'h00, rnd128(), rnd128(), "R8");
        step(1, 2'b01, 8'h4E, rnd128(), '0, "R2");
        step(1, 2'b11, 8'h0E, HI, result, "R10");
        step(1, 2'b11, 8'h07, rnd128(), result, "R10");
        step(1, 2'b11, 8'h0B, rnd128(), result, "R10");

        @(negedge clk);
        compare();
        rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        compare();
        @(negedge clk);
        compare();
        rst = 1'b0;
        in_valid = 1'b0;

        for (int k = 0; k < 200; k++) begin
            logic [1:0] sz;
            string t;
            sz = 2'($urandom);
            t = (sz == 2'b00) ? "R1" : (sz == 2'b01) ? "R2" : (sz == 2'b10) ? "R3" : "R5";
            step(1'($urandom % 4 != 0), sz, 8'($urandom), rnd128(), rnd128(), t);
        end
        step(0, 2'b00, 8'h00, '0, '0, "R8");
        @(negedge clk);
        compare();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule